// File: doc/BRIEF.md
# Instruction-Fetch Breakpoint Comparator Unit

This debug unit sits beside a processor's instruction-fetch path and holds a small bank of address comparators. Each comparator names one word in the low 512 MB code region. A two-bit selector picks whether the lower halfword, the upper halfword or both halfwords of that word trigger a breakpoint. When a valid fetch hits an enabled comparator while the unit is globally enabled, the unit emits a one-cycle halt request on the next clock edge. It also reports the lowest index among the comparators that matched. The core's halt logic then stops execution before the fetched instruction retires.

Software configures the unit over a simple single-cycle register bus. The control word is at byte offset 0x000. It holds the global enable, a read-only comparator count split across two fields, and a read-only revision field that reads 0. A write to the control word takes effect only when the key bit is set in the written data. Comparator slot n is at byte offset 0x008 + 4·n. Offset 0x004 is a reserved hole. Matching runs in a two-state event machine: WATCH is the default state, and FIRE lasts one cycle after each qualifying fetch. The WATCH→FIRE transition is called "hit". FIRE→FIRE is "hit again", FIRE→WATCH is "release", and WATCH→WATCH is "idle".

Top module: `fetch_bkpt_unit`

## Requirements
- R1: After reset the global enable reads 0, every comparator reads 0, and `dbg_halt` is low.
- R2: A bus write to offset 0x000 updates the global enable (bit 0) only when written data bit 1 (the key) is 1. Otherwise the write leaves the control state unchanged.
- R3: Reading offset 0x000 returns the enable in bit 0. It returns the comparator count NUM_CMP split so that count[6:4] is at bits [14:12] and count[3:0] is at bits [7:4]. The revision is in bits [31:28] and is 0, and all other bits read 0.
- R4: A comparator word holds the slot enable in bit 0, the word address in bits [28:2] and the replace selector in bits [31:30]. Bits 1 and 29 read 0. Comparator writes need no key.
- R5: The replace selector works as follows. 01 matches a fetch with address bit 1 = 0 (lower halfword). 10 matches a fetch with address bit 1 = 1 (upper halfword). 11 matches both. 00 never matches.
- R6: A fetch can match only if its address bits [31:29] are 0. The comparison uses fetch bits [28:1] only, so fetch bit 0 is ignored.
- R7: With the global enable at 0, or with a slot's enable at 0, that slot raises no halt.
- R8: `dbg_halt` is high for exactly the one cycle after the clock edge that samples a qualifying fetch with `fetch_valid` high. With `fetch_valid` low, no halt is raised.
- R9: When several comparators match the same fetch, one halt pulse is produced and `hit_idx` gives the lowest matching slot index.
- R10: Offset 0x004 and comparator slots at or beyond NUM_CMP read 0, and writes to them change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not selected |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch byte address |
| dbg_halt | output | 1 | One-cycle debug halt request |
| hit_idx | output | IDX_W (2) | Lowest matching comparator index, valid with dbg_halt |

## Verification
The bench sweeps every slot against every replace code and every byte offset of the programmed word, as well as a neighbouring word. If the design swapped the halfword selector bits, halts would land on the wrong half. If it compared fetch bit 0, odd addresses would be missed. The region test walks all eight values of the top three address bits and expects a halt only for the code region, so a design that dropped the region guard would halt on SRAM fetches. Further checks cover unkeyed control writes, the reserved hole and out-of-range slot offsets, and simultaneous hits. These catch a design that accepts every control write, aliases phantom slots onto real ones, or picks the highest rather than the lowest matching index.

// File: rtl/fbk_pkg.sv
package fbk_pkg;

    // Field positions inside the control word
    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_KEY_BIT = 1;

    typedef struct packed {
        logic [1:0]  repl;   // halfword selector
        logic [26:0] waddr;  // word address bits [28:2]
        logic        en;     // slot enable
    } bkpt_slot_t;

    typedef enum logic {
        EV_WATCH = 1'b0,
        EV_FIRE  = 1'b1
    } ev_state_t;

    function automatic logic [31:0] slot_to_word(input bkpt_slot_t s);
        return {s.repl, 1'b0, s.waddr, 1'b0, s.en};
    endfunction

    function automatic bkpt_slot_t word_to_slot(input logic [31:0] w);
        bkpt_slot_t s;
        s.repl  = w[31:30];
        s.waddr = w[28:2];
        s.en    = w[0];
        return s;
    endfunction

endpackage

// File: rtl/fbk_regfile.sv
module fbk_regfile
    import fbk_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_sel,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     glob_en,
    output bkpt_slot_t [NUM_CMP-1:0] slots
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [6:0] CNT7 = 7'(NUM_CMP);
    localparam logic [WIDX_W-1:0] CTRL_IDX = '0;

    logic [WIDX_W-1:0] widx;
    logic              ctrl_wr;
    logic [31:0]       ctrl_word;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign ctrl_wr = bus_sel && bus_wr && (widx == CTRL_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glob_en <= 1'b0;
        end else if (ctrl_wr && bus_wdata[CTRL_KEY_BIT]) begin
            glob_en <= bus_wdata[CTRL_EN_BIT];
        end
    end

    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_slot
            localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(g + 2);
            logic slot_wr;
            assign slot_wr = bus_sel && bus_wr && (widx == MY_IDX);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slots[g] <= '0;
                end else if (slot_wr) begin
                    slots[g] <= word_to_slot(bus_wdata);
                end
            end
        end
    endgenerate

    always_comb begin
        ctrl_word          = '0;
        ctrl_word[0]       = glob_en;
        ctrl_word[7:4]     = CNT7[3:0];
        ctrl_word[14:12]   = CNT7[6:4];
        ctrl_word[31:28]   = 4'h0;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (widx == CTRL_IDX) begin
                bus_rdata = ctrl_word;
            end
            for (int i = 0; i < NUM_CMP; i++) begin
                if (widx == WIDX_W'(i + 2)) begin
                    bus_rdata = slot_to_word(slots[i]);
                end
            end
        end
    end

    // R2: unkeyed control writes leave the enable untouched
    assert_unkeyed_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == '0 && !bus_wdata[CTRL_KEY_BIT]) |=> $stable(glob_en));

    // R2: keyed control writes load the enable
    assert_keyed_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == '0 && bus_wdata[CTRL_KEY_BIT])
            |=> (glob_en == $past(bus_wdata[CTRL_EN_BIT])));

endmodule

// File: rtl/fbk_match.sv
module fbk_match
    import fbk_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int IDX_W   = 2
) (
    input  logic [31:0]              fetch_addr,
    input  bkpt_slot_t [NUM_CMP-1:0] slots,
    output logic                     any_hit,
    output logic [IDX_W-1:0]         low_idx
);

    logic              in_code;
    logic [NUM_CMP-1:0] hit_vec;

    assign in_code = (fetch_addr[31:29] == 3'b000);

    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
            logic word_eq;
            logic half_ok;
            assign word_eq = (slots[g].waddr == fetch_addr[28:2]);
            assign half_ok = fetch_addr[1] ? slots[g].repl[1] : slots[g].repl[0];
            assign hit_vec[g] = slots[g].en && in_code && word_eq && half_ok;
        end
    endgenerate

    always_comb begin
        low_idx = '0;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                low_idx = IDX_W'(i);
            end
        end
    end

    assign any_hit = |hit_vec;

endmodule

// File: rtl/fbk_event.sv
module fbk_event
    import fbk_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fetch_valid,
    input  logic             glob_en,
    input  logic             any_hit,
    input  logic [IDX_W-1:0] low_idx,
    output logic             halt,
    output logic [IDX_W-1:0] idx_out
);

    ev_state_t        state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             qualify;

    assign qualify = fetch_valid && glob_en && any_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EV_WATCH: state_d = qualify ? EV_FIRE : EV_WATCH;   // hit / idle
            EV_FIRE:  state_d = qualify ? EV_FIRE : EV_WATCH;   // hit again / release
            default:  state_d = EV_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_WATCH;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= qualify ? low_idx : '0;
        end
    end

    always_comb begin
        halt    = (state_q == EV_FIRE);
        idx_out = halt ? idx_q : '0;
    end

    // R8: a halt pulse always follows a valid fetch
    assert_halt_after_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> $past(fetch_valid));

    // R7: no halt follows a cycle where the unit was disabled
    assert_halt_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> $past(glob_en));

endmodule

// File: rtl/fetch_bkpt_unit.sv
module fetch_bkpt_unit
    import fbk_pkg::*;
#(
    parameter int NUM_CMP = 4,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    output logic              dbg_halt,
    output logic [IDX_W-1:0]  hit_idx
);

    logic                     glob_en;
    bkpt_slot_t [NUM_CMP-1:0] slots;
    logic                     any_hit;
    logic [IDX_W-1:0]         low_idx;

    fbk_regfile #(.NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .glob_en   (glob_en),
        .slots     (slots)
    );

    fbk_match #(.NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) u_match (
        .fetch_addr (fetch_addr),
        .slots      (slots),
        .any_hit    (any_hit),
        .low_idx    (low_idx)
    );

    fbk_event #(.IDX_W(IDX_W)) u_event (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_valid (fetch_valid),
        .glob_en     (glob_en),
        .any_hit     (any_hit),
        .low_idx     (low_idx),
        .halt        (dbg_halt),
        .idx_out     (hit_idx)
    );

    // R6: fetches outside the code region never lead to a halt
    assert_no_data_region_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_addr[31:29] != 3'b000) |=> !dbg_halt);

    // R7: a globally disabled unit raises no halt
    assert_disabled_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !glob_en) |=> !dbg_halt);

    // R8: no valid fetch, no halt in the following cycle
    assert_idle_no_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !dbg_halt);

endmodule

// File: tb/fetch_bkpt_unit_test.sv
module fetch_bkpt_unit_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int AW         = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          fetch_valid = 1'b0;
    logic [31:0]   fetch_addr = '0;
    logic          dbg_halt;
    logic [1:0]    hit_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fetch_bkpt_unit #(.NUM_CMP(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .dbg_halt(dbg_halt), .hit_idx(hit_idx)
    );

    localparam logic [31:0] CNT_FIELD = (32'((N >> 4) & 7) << 12) | (32'(N & 15) << 4);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(req, d, exp);
    endtask

    // Drive one fetch, then check the halt in the following cycle
    task automatic fetch_chk(input string req, input logic v, input logic [31:0] a,
                             input logic eh, input int ei);
        @(negedge clk);
        fetch_valid = v; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk(req, {31'b0, dbg_halt}, {31'b0, eh});
        if (eh) chk(req, {30'b0, hit_idx}, 32'(ei));
    endtask

    function automatic logic [AW-1:0] slot_off(input int s);
        return AW'(8 + 4 * s);
    endfunction

    function automatic logic [31:0] slot_word(input logic [1:0] r, input logic [31:0] byte_addr,
                                              input logic en);
        return {r, 1'b0, byte_addr[28:2], 1'b0, en};
    endfunction

    task automatic clear_slots();
        for (int s = 0; s < N; s++) bus_write(slot_off(s), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state, R3 control layout
        chk("R1 halt after reset", {31'b0, dbg_halt}, 32'h0);
        read_chk("R1 R3 control after reset", 12'h000, CNT_FIELD);
        for (int s = 0; s < N; s++) read_chk("R1 comparator after reset", slot_off(s), 32'h0);

        // R2 key gating
        bus_write(12'h000, 32'h0000_0001);
        read_chk("R2 unkeyed write ignored", 12'h000, CNT_FIELD);
        bus_write(12'h000, 32'hFFFF_FFFD);
        read_chk("R2 unkeyed all-ones ignored", 12'h000, CNT_FIELD);
        bus_write(12'h000, 32'hFFFF_FFFF);
        read_chk("R2 R3 keyed write sets enable", 12'h000, CNT_FIELD | 32'h1);
        bus_write(12'h000, 32'h0000_0002);
        read_chk("R2 keyed write clears enable", 12'h000, CNT_FIELD);
        bus_write(12'h000, 32'h0000_0003);

        // R4 comparator layout
        bus_write(slot_off(0), 32'hFFFF_FFFF);
        read_chk("R4 reserved bits read zero", slot_off(0), 32'hDFFF_FFFD);
        bus_write(slot_off(0), 32'h4000_0240 | 32'h1);
        read_chk("R4 field round trip", slot_off(0), 32'h4000_0241);
        clear_slots();

        // R10 hole and phantom slots
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(slot_off(N), 32'hFFFF_FFFF);
        bus_write(slot_off(N + 5), 32'hFFFF_FFFF);
        read_chk("R10 hole reads zero", 12'h004, 32'h0);
        read_chk("R10 phantom slot reads zero", slot_off(N), 32'h0);
        for (int s = 0; s < N; s++) read_chk("R10 real slot untouched", slot_off(s), 32'h0);
        read_chk("R10 control untouched", 12'h000, CNT_FIELD | 32'h1);

        // R5 R6 sweep: every slot x replace code x byte offset, plus a neighbour word
        for (int s = 0; s < N; s++) begin
            for (int r = 0; r < 4; r++) begin
                logic [31:0] base;
                base = 32'h100 + 32'(s) * 32'h10;
                clear_slots();
                bus_write(slot_off(s), slot_word(2'(r), base, 1'b1));
                for (int off = 0; off < 8; off++) begin
                    logic [31:0] fa;
                    logic exp_h;
                    fa = base + 32'(off);
                    exp_h = (fa[28:2] == base[28:2]) && (fa[1] ? r[1] : r[0]);
                    fetch_chk("R5 R6 replace sweep", 1'b1, fa, exp_h, s);
                end
            end
        end

        // R6 region: walk top three address bits
        clear_slots();
        bus_write(slot_off(0), slot_word(2'b11, 32'h240, 1'b1));
        for (int k = 0; k < 8; k++) begin
            fetch_chk("R6 code region only", 1'b1, {3'(k), 29'h240}, (k == 0), 0);
        end

        // R8 pulse width and fetch_valid qualification
        fetch_chk("R8 no halt without fetch_valid", 1'b0, 32'h240, 1'b0, 0);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = 32'h242;
        @(negedge clk);
        fetch_valid = 1'b0;
        chk("R8 halt in following cycle", {31'b0, dbg_halt}, 32'h1);
        @(negedge clk);
        chk("R8 halt lasts one cycle", {31'b0, dbg_halt}, 32'h0);

        // R7 enables
        bus_write(12'h000, 32'h0000_0002);
        fetch_chk("R7 global disable blocks", 1'b1, 32'h240, 1'b0, 0);
        bus_write(12'h000, 32'h0000_0003);
        bus_write(slot_off(0), slot_word(2'b11, 32'h240, 1'b0));
        fetch_chk("R7 slot disable blocks", 1'b1, 32'h240, 1'b0, 0);

        // R9 simultaneous hits
        clear_slots();
        bus_write(slot_off(1), slot_word(2'b11, 32'h300, 1'b1));
        bus_write(slot_off(2), slot_word(2'b01, 32'h300, 1'b1));
        bus_write(slot_off(3), slot_word(2'b11, 32'h300, 1'b1));
        fetch_chk("R9 lowest of slots 1,3", 1'b1, 32'h302, 1'b1, 1);
        fetch_chk("R9 lowest of slots 1,2,3", 1'b1, 32'h300, 1'b1, 1);
        bus_write(slot_off(1), slot_word(2'b10, 32'h300, 1'b1));
        fetch_chk("R9 next lowest after reselect", 1'b1, 32'h300, 1'b1, 2);
        @(negedge clk);
        chk("R9 single pulse", {31'b0, dbg_halt}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule